// File: doc/BRIEF.md
# Peripheral Clock Source-Divide-Gate Unit

This block produces the clock for one peripheral from a choice of four reference
clocks. Each reference is modelled as a one-cycle enable strobe inside a single
system clock domain. The unit takes the strobes of one chosen reference and
divides them through two cascaded counters. It emits a one-cycle enable pulse
each time the combined count completes. A disable bit can hold that pulse off.

Software sets the unit through a small synchronous register port. The port has a
byte address and 32-bit data. A reference select, two 3-bit stage ratios and the
disable bit are stored at fixed word offsets. The overall ratio is the product of
the two stages. A stage code of 0 or 7 is invalid, and an invalid code silences
the output instead of passing the reference through. A change of source or ratio
is held back until the current output period ends. A period therefore never ends
early because of a register write.

Top module: `periph_clk_unit`

## Requirements
- R1: Offset 0x00 bits [1:0] select the reference: 0 uses `ref_tick[0]` (A primary), 1 uses `ref_tick[1]` (B primary), 2 uses `ref_tick[2]` (A secondary), 3 uses `ref_tick[3]` (B secondary).
- R2: The stage-one ratio is at offset 0x04 bits [2:0] and the stage-two ratio is at offset 0x08 bits [2:0]. Valid codes are 1 to 6. With valid codes d1 and d2, `clk_en_o` pulses once for every d1*d2 strobes of the selected reference. The pulse appears in the cycle after the strobe that completes the count.
- R3: While either active stage code is 0 or 7, `clk_en_o` stays low and the count is held at zero.
- R4: Offset 0x14 bit 0 is a disable bit. When it is 1, every pulse from the following cycle on is suppressed, and counting continues. When it is 0, pulses pass.
- R5: A new source or ratio takes effect only after the pulse that ends the current period. When the active setting is invalid, a new setting is taken up in the cycle after it is written.
- R6: A read with `rd_en` returns the addressed word on `rd_data` one cycle later, and `rd_data` holds between reads. Bits outside the defined fields read as zero, and offsets 0x0C and 0x10 read as zero.
- R7: Reset clears every register and the count. No pulse appears until both ratios have been programmed with valid codes.
- R8: A write to an address that is not one of the four defined field offsets changes nothing that can be read or observed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 4 | Enable strobes of the four reference clocks |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 5 | Byte address of the read |
| rd_data | output | 32 | Read data, valid one cycle after `rd_en` |
| clk_en_o | output | 1 | One-cycle enable pulse at the divided rate |

## Verification
The assertions assume that reference strobes are known, single-cycle levels in every clock after reset. They also assume that the register port never leaves its strobes or addresses unknown. The bench meets both conditions by driving all inputs to defined values at the falling edge, starting before reset is released. The bench mixes directed sequences and random register traffic. The random traffic writes mostly valid codes, with occasional 0 and 7, so the unit moves in and out of its idle state many times while some strobes arrive irregularly.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
    localparam int NUM_REF   = 4;
    localparam int SEL_W     = $clog2(NUM_REF);
    localparam int RATIO_W   = 3;
    localparam int RATIO_MAX = 6;
    localparam int NUM_STG   = 2;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 32;

    localparam logic [ADDR_W-1:0] OFS_SRC  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_STG1 = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_STG2 = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_RSV0 = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_RSV1 = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_GATE = 5'h14;

    typedef struct packed {
        logic [SEL_W-1:0]   src;
        logic [RATIO_W-1:0] r1;
        logic [RATIO_W-1:0] r2;
    } path_cfg_t;

    function automatic logic ratio_ok(input logic [RATIO_W-1:0] code);
        return (code != '0) && (int'(code) <= RATIO_MAX);
    endfunction
endpackage

// File: rtl/pclk_regs.sv
module pclk_regs
    import pclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output path_cfg_t         cfg,
    output logic              gate_off
);
    path_cfg_t         cfg_q;
    logic              off_q;
    logic [DATA_W-1:0] rd_q;
    logic [DATA_W-1:0] rd_mux;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            off_q <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                OFS_SRC:  cfg_q.src <= wr_data[SEL_W-1:0];
                OFS_STG1: cfg_q.r1  <= wr_data[RATIO_W-1:0];
                OFS_STG2: cfg_q.r2  <= wr_data[RATIO_W-1:0];
                OFS_GATE: off_q     <= wr_data[0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (rd_addr)
            OFS_SRC:  rd_mux = DATA_W'(cfg_q.src);
            OFS_STG1: rd_mux = DATA_W'(cfg_q.r1);
            OFS_STG2: rd_mux = DATA_W'(cfg_q.r2);
            OFS_GATE: rd_mux = DATA_W'(off_q);
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_q <= '0;
        else if (rd_en) rd_q <= rd_mux;
    end

    assign rd_data  = rd_q;
    assign cfg      = cfg_q;
    assign gate_off = off_q;
endmodule

// File: rtl/pclk_stage.sv
module pclk_stage #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    localparam logic [W-1:0] ONE = W'(1);
    logic [W-1:0] cnt_q;
    logic         at_end;

    assign at_end = (cnt_q == (limit - ONE));
    assign wrap   = step && at_end && !clr;

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt_q <= '0;
        else if (step)   cnt_q <= at_end ? '0 : cnt_q + ONE;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/periph_clk_unit.sv
module periph_clk_unit
    import pclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        ref_tick,
    input  logic              wr_en,
    input  logic [4:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    input  logic [4:0]        rd_addr,
    output logic [31:0]       rd_data,
    output logic              clk_en_o
);
    path_cfg_t cfg;
    path_cfg_t act_q;
    logic      gate_off;
    logic      act_valid;
    logic      sel_tick;
    logic      fire;
    logic      out_q;

    logic [NUM_STG-1:0][RATIO_W-1:0] stg_lim;
    logic [NUM_STG-1:0][RATIO_W-1:0] stg_cnt;
    logic [NUM_STG-1:0]              stg_step;
    logic [NUM_STG-1:0]              stg_wrap;

    pclk_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .cfg      (cfg),
        .gate_off (gate_off)
    );

    assign act_valid  = ratio_ok(act_q.r1) && ratio_ok(act_q.r2);
    assign sel_tick   = ref_tick[act_q.src];
    assign stg_lim[0] = act_q.r1;
    assign stg_lim[1] = act_q.r2;

    for (genvar i = 0; i < NUM_STG; i++) begin : g_stg
        if (i == 0) begin : g_first
            assign stg_step[i] = act_valid && sel_tick;
        end else begin : g_next
            assign stg_step[i] = stg_wrap[i-1];
        end
        pclk_stage #(.W(RATIO_W)) u_stage (
            .clk   (clk),
            .rst   (rst),
            .clr   (!act_valid),
            .step  (stg_step[i]),
            .limit (stg_lim[i]),
            .cnt   (stg_cnt[i]),
            .wrap  (stg_wrap[i])
        );
    end

    assign fire = stg_wrap[NUM_STG-1];

    // Active setting reloads only at a period boundary or while idle.
    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            out_q <= 1'b0;
        end else begin
            if (fire || !act_valid) act_q <= cfg;
            out_q <= fire && !gate_off;
        end
    end

    assign clk_en_o = out_q;
endmodule

// File: rtl/periph_clk_unit_chk.sv
module periph_clk_unit_chk
    import pclk_pkg::*;
(
    input logic                            clk,
    input logic                            rst,
    input logic                            clk_en_o,
    input logic                            gate_off,
    input logic                            act_valid,
    input logic                            fire,
    input logic                            sel_tick,
    input path_cfg_t                       act_q,
    input logic [NUM_STG-1:0][RATIO_W-1:0] stg_cnt,
    input logic [NUM_STG-1:0][RATIO_W-1:0] stg_lim,
    input logic                            rd_en,
    input logic [ADDR_W-1:0]               rd_addr,
    input logic [DATA_W-1:0]               rd_data
);
    AST_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        clk_en_o |-> $past(sel_tick)); // R1
    AST_STAGE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        act_valid |-> (stg_cnt[0] < stg_lim[0]) && (stg_cnt[1] < stg_lim[1])); // R2
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        !act_valid |=> !clk_en_o); // R3
    AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        gate_off |=> !clk_en_o); // R4
    AST_CFG_HELD_MIDPERIOD: assert property (@(posedge clk) disable iff (rst)
        (act_valid && !fire) |=> $stable(act_q)); // R5
    AST_GAP_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (rd_addr == OFS_RSV0 || rd_addr == OFS_RSV1)) |=> (rd_data == '0)); // R6
endmodule

bind periph_clk_unit periph_clk_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .clk_en_o  (clk_en_o),
    .gate_off  (gate_off),
    .act_valid (act_valid),
    .fire      (fire),
    .sel_tick  (sel_tick),
    .act_q     (act_q),
    .stg_cnt   (stg_cnt),
    .stg_lim   (stg_lim),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data)
);

// File: tb/periph_clk_unit_tb.sv
`timescale 1ns/1ps
module periph_clk_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  ref_tick = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        clk_en_o;

    always #10 clk = ~clk; // 50 MHz

    periph_clk_unit u_dut (
        .clk(clk), .rst(rst), .ref_tick(ref_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .clk_en_o(clk_en_o)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    n_pulse = 0;
    int    cyc = 0;
    bit    started = 0;
    bit    done = 0;
    string req = "R7";

    // reference model state
    int m_src, m_r1, m_r2, m_off;
    int a_src, a_r1, a_r2;
    int count;
    bit exp_out;
    int unsigned exp_rd;

    function automatic bit code_ok(int c);
        return (c >= 1) && (c <= 6);
    endfunction

    function automatic int unsigned model_read(int a);
        case (a)
            'h00: return m_src;
            'h04: return m_r1;
            'h08: return m_r2;
            'h14: return m_off;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_src = 0; m_r1 = 0; m_r2 = 0; m_off = 0;
            a_src = 0; a_r1 = 0; a_r2 = 0; count = 0;
            exp_out = 0; exp_rd = 0;
        end else begin
            bit vld, tk, fr;
            vld = code_ok(a_r1) && code_ok(a_r2);
            tk  = ref_tick[a_src];
            fr  = vld && tk && (count == a_r1 * a_r2 - 1);
            exp_out = fr && (m_off == 0);
            if (vld && tk) count = fr ? 0 : count + 1;
            if (fr || !vld) begin
                a_src = m_src; a_r1 = m_r1; a_r2 = m_r2; count = 0;
            end
            if (rd_en) exp_rd = model_read(int'(rd_addr));
            if (wr_en) begin
                case (wr_addr)
                    5'h00: m_src = int'(wr_data[1:0]);
                    5'h04: m_r1  = int'(wr_data[2:0]);
                    5'h08: m_r2  = int'(wr_data[2:0]);
                    5'h14: m_off = int'(wr_data[0]);
                    default: ;
                endcase
            end
        end
        started = 1;
    end

    always @(negedge clk) begin
        if (started && !done) begin
            n_cmp++;
            if (clk_en_o !== exp_out) begin
                n_bad++;
                $display("FAIL %s clk_en_o cycle %0d: actual %b expected %b",
                         req, cyc, clk_en_o, exp_out);
            end
            n_cmp++;
            if (rd_data !== exp_rd) begin
                n_bad++;
                $display("FAIL %s rd_data cycle %0d: actual %h expected %h",
                         req, cyc, rd_data, exp_rd);
            end
            if (clk_en_o === 1'b1) n_pulse++;
        end
        cyc++;
        ref_tick[0] <= 1'b1;
        ref_tick[1] <= (cyc % 2) == 0;
        ref_tick[2] <= (cyc % 3) == 0;
        ref_tick[3] <= $urandom_range(0, 1) == 1;
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en <= 1'b1; wr_addr <= a; wr_data <= d;
        @(negedge clk);
        wr_en <= 1'b0;
    endtask

    task automatic rd(input logic [4:0] a);
        @(negedge clk);
        rd_en <= 1'b1; rd_addr <= a;
        @(negedge clk);
        rd_en <= 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int p0;
        repeat (4) @(negedge clk);
        rst <= 1'b0;
        req = "R7"; p0 = n_pulse;   // nothing before programming
        idle(30);
        rd(5'h04); rd(5'h14);
        n_cmp++;
        if (n_pulse != p0) begin
            n_bad++;
            $display("FAIL R7 pulses after reset: actual %0d expected 0", n_pulse - p0);
        end

        req = "R6";
        wr(5'h00, 32'hFFFF_FFFE); rd(5'h00);
        wr(5'h04, 32'hFFFF_FFF9); rd(5'h04);
        wr(5'h14, 32'h0000_0002); rd(5'h14);
        rd(5'h0C); rd(5'h10); idle(3);

        req = "R2";
        wr(5'h00, 0); wr(5'h04, 2); wr(5'h08, 3);
        idle(60);
        wr(5'h04, 1); wr(5'h08, 1); idle(20);
        wr(5'h04, 6); wr(5'h08, 6); idle(100);

        req = "R1";
        wr(5'h04, 2); wr(5'h08, 2);
        for (int s = 1; s < 4; s++) begin
            wr(5'h00, s); idle(60);
        end

        req = "R5";
        wr(5'h00, 0); wr(5'h04, 5); wr(5'h08, 4); idle(7);
        wr(5'h04, 3); idle(3); wr(5'h00, 2); idle(80);

        req = "R3";
        wr(5'h04, 7); idle(60);
        wr(5'h04, 2); wr(5'h08, 0); idle(40);
        wr(5'h08, 2); idle(30);

        req = "R4";
        wr(5'h14, 1); idle(40);
        wr(5'h14, 0); idle(30);

        req = "R8";
        wr(5'h0C, 32'hFFFF_FFFF); wr(5'h10, 32'hFFFF_FFFF);
        wr(5'h01, 32'h7); wr(5'h18, 32'h1); wr(5'h15, 32'h1);
        rd(5'h0C); rd(5'h10); rd(5'h00); rd(5'h04); rd(5'h14); idle(30);

        req = "R5";
        for (int i = 0; i < 3000; i++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op == 0) begin
                logic [4:0] a;
                case ($urandom_range(0, 4))
                    0: a = 5'h00; 1: a = 5'h04; 2: a = 5'h08;
                    3: a = 5'h14; default: a = 5'h10;
                endcase
                wr(a, (a == 5'h14) ? (($urandom_range(0, 5) == 0) ? 1 : 0)
                                   : $urandom_range(0, 7));
            end else if (op == 1) begin
                rd(5'($urandom_range(0, 31)));
            end else begin
                idle(1);
            end
        end
        idle(5);
        finish_run();
    end
endmodule